// File: doc/BRIEF.md
# Saturating ALU with status flags

This block is a 16-bit two's-complement arithmetic and logic unit with a registered result and a registered set of six status flags. It starts one operation on every clock edge. The operation works on two operands, `x_in` and `y_in`, under a 5-bit operation code. The result and the flags appear on the outputs one clock later.

The carry-in for the chained forms is the stored carry flag. This flag was produced by the operation on the previous clock, so multi-word additions and subtractions can be built one word per cycle, starting from the low word.

A mode input, `sat_en`, turns on saturation of the value loaded into the result register. While the mode is held high, every operation that overflows loads the positive or negative full-scale value instead of the wrapped sum. The choice between the two comes from the overflow and carry flags of that operation. The mode is a level that stays in force until it is cleared. It is not a per-operation choice.

Top module: `sat_alu`

## Requirements
- R1: While `rst` is high at a rising edge, `r_out` and all six flags are loaded with 0.
- R2: Opcodes are decoded as follows, and each code produces the listed 16-bit result:
  - 0: X+Y
  - 1: X+Y+CI
  - 2: X−Y
  - 3: X−Y+CI−1
  - 4: Y−X
  - 5: Y−X+CI−1
  - 6: −X
  - 7: −Y
  - 8: Y+1
  - 9: Y−1
  - 10: X
  - 11: Y
  - 12: 0
  - 13: |X|
  - 14: X AND Y
  - 15: X OR Y
  - 16: X XOR Y
  - 17: NOT X
  - 18: NOT Y
- R3: CI for opcodes 1, 3 and 5 is the `ac` flag currently held. That is the carry produced by the operation of the previous clock.
- R4: Each arithmetic opcode is one addition A+B+C. The forms are:
  - subtractions: X+~Y+1, X+~Y+CI, Y+~X+1 and Y+~X+CI
  - negations: 0+~X+1 and 0+~Y+1
  - increment: Y+0+1
  - decrement: Y+0xFFFF+0
  - absolute value: 0+~X+1 for negative X, and X+0+0 otherwise

  `ac` is the carry out of bit 15 of that addition, so 1 means no borrow. `av` is 1 when the signed value of the operation lies outside −32768..32767.
- R5: For opcodes 10, 11, 12 and 14 to 18, and for every undefined code, `ac` and `av` are 0.
- R6: `az` is 1 exactly when the unsaturated ALU output is zero, and `an` is bit 15 of that output.
- R7: The absolute value of 0x8000 gives 0x8000 with `av`=1.
- R8: `x_sign` is bit 15 of the X operand of the operation, and `aq` is always 0.
- R9: With `sat_en`=1 and `av`=0, `r_out` is the unsaturated ALU output, whatever the value of `ac`.
- R10: With `sat_en`=1 and `av`=1, `r_out` is 0x7FFF when `ac`=0 and 0x8000 when `ac`=1.
- R11: With `sat_en`=0, `r_out` is the wrapped ALU output, even on overflow.
- R12: Undefined opcodes 19 to 31 behave as code 12: the result is 0, `az`=1, and the other flags follow R5, R6 and R8.
- R13: Inputs present at a rising edge determine `r_out` and the flags that are visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sat_en | input | 1 | Saturation mode for the result register |
| opcode | input | 5 | Operation code (R2) |
| x_in | input | 16 | X operand |
| y_in | input | 16 | Y operand |
| r_out | output | 16 | Registered result |
| az | output | 1 | Zero flag |
| an | output | 1 | Negative flag |
| ac | output | 1 | Carry flag, also the next carry-in |
| av | output | 1 | Overflow flag |
| x_sign | output | 1 | Sign of the X operand |
| aq | output | 1 | Quotient flag placeholder, always 0 |

## Verification
The properties assume the following about the inputs:
- `opcode`, `x_in`, `y_in` and `sat_en` carry known values at every rising edge.
- `rst` is high at the first edge.
- Every code in the 5-bit opcode space, including the undefined ones, is legal.

The stimulus changes inputs only on falling edges, holds reset for the first cycles, and sweeps all 32 codes. It crosses them with operands 0, 1, 0x7FFF, 0x8000 and 0xFFFF, with saturation both on and off, and then adds random traffic. The carry-in of the chained forms comes from whatever the previous operation left, so both carry-in values reach opcodes 1, 3 and 5.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_ADDC  = 5'd1,
    OP_SUB   = 5'd2,
    OP_SUBB  = 5'd3,
    OP_RSUB  = 5'd4,
    OP_RSUBB = 5'd5,
    OP_NEGX  = 5'd6,
    OP_NEGY  = 5'd7,
    OP_INCY  = 5'd8,
    OP_DECY  = 5'd9,
    OP_PASSX = 5'd10,
    OP_PASSY = 5'd11,
    OP_ZERO  = 5'd12,
    OP_ABSX  = 5'd13,
    OP_AND   = 5'd14,
    OP_OR    = 5'd15,
    OP_XOR   = 5'd16,
    OP_NOTX  = 5'd17,
    OP_NOTY  = 5'd18
  } alu_op_e;

  typedef struct packed {
    logic az;
    logic an;
    logic ac;
    logic av;
    logic xs;
    logic aq;
  } alu_flags_t;

endpackage

// File: rtl/sat_alu_adder.sv
module sat_alu_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  logic [WIDTH:0] full;

  always_comb begin
    full = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
    sum  = full[WIDTH-1:0];
    cout = full[WIDTH];
    ovf  = (a[WIDTH-1] == b[WIDTH-1]) && (full[WIDTH-1] != a[WIDTH-1]);
  end
endmodule

// File: rtl/sat_alu_core.sv
module sat_alu_core
  import sat_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [4:0]       opcode,
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             ci,
  output logic [WIDTH-1:0] res,
  output alu_flags_t       flags
);
  localparam logic [WIDTH-1:0] ZERO_W = '0;
  localparam logic [WIDTH-1:0] ONES_W = '1;

  logic [WIDTH-1:0] opa, opb, lres, sum;
  logic             cin, use_add, cout, ovf;

  // One shared adder; each arithmetic code only picks its operands.
  always_comb begin
    opa     = ZERO_W;
    opb     = ZERO_W;
    cin     = 1'b0;
    use_add = 1'b1;
    lres    = ZERO_W;
    case (alu_op_e'(opcode))
      OP_ADD:   begin opa = x; opb = y; end
      OP_ADDC:  begin opa = x; opb = y; cin = ci; end
      OP_SUB:   begin opa = x; opb = ~y; cin = 1'b1; end
      OP_SUBB:  begin opa = x; opb = ~y; cin = ci; end
      OP_RSUB:  begin opa = y; opb = ~x; cin = 1'b1; end
      OP_RSUBB: begin opa = y; opb = ~x; cin = ci; end
      OP_NEGX:  begin opb = ~x; cin = 1'b1; end
      OP_NEGY:  begin opb = ~y; cin = 1'b1; end
      OP_INCY:  begin opa = y; cin = 1'b1; end
      OP_DECY:  begin opa = y; opb = ONES_W; end
      OP_ABSX: begin
        if (x[WIDTH-1]) begin
          opb = ~x;
          cin = 1'b1;
        end else begin
          opa = x;
        end
      end
      OP_PASSX: begin use_add = 1'b0; lres = x; end
      OP_PASSY: begin use_add = 1'b0; lres = y; end
      OP_AND:   begin use_add = 1'b0; lres = x & y; end
      OP_OR:    begin use_add = 1'b0; lres = x | y; end
      OP_XOR:   begin use_add = 1'b0; lres = x ^ y; end
      OP_NOTX:  begin use_add = 1'b0; lres = ~x; end
      OP_NOTY:  begin use_add = 1'b0; lres = ~y; end
      default:  begin use_add = 1'b0; lres = ZERO_W; end
    endcase
  end

  sat_alu_adder #(.WIDTH(WIDTH)) u_add (
    .a    (opa),
    .b    (opb),
    .cin  (cin),
    .sum  (sum),
    .cout (cout),
    .ovf  (ovf)
  );

  always_comb begin
    res      = use_add ? sum : lres;
    flags.az = (res == ZERO_W);
    flags.an = res[WIDTH-1];
    flags.ac = use_add & cout;
    flags.av = use_add & ovf;
    flags.xs = x[WIDTH-1];
    flags.aq = 1'b0;
  end
endmodule

// File: rtl/sat_alu_clamp.sv
module sat_alu_clamp #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] raw,
  input  logic             sat_en,
  input  logic             av,
  input  logic             ac,
  output logic [WIDTH-1:0] load_val
);
  localparam logic [WIDTH-1:0] FULL_POS = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] FULL_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  always_comb begin
    if (sat_en && av) load_val = ac ? FULL_NEG : FULL_POS;
    else              load_val = raw;
  end
endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sat_en,
  input  logic [4:0]       opcode,
  input  logic [WIDTH-1:0] x_in,
  input  logic [WIDTH-1:0] y_in,
  output logic [WIDTH-1:0] r_out,
  output logic             az,
  output logic             an,
  output logic             ac,
  output logic             av,
  output logic             x_sign,
  output logic             aq
);
  logic [WIDTH-1:0] raw, load_val;
  alu_flags_t       nxt, flg_q;

  sat_alu_core #(.WIDTH(WIDTH)) u_core (
    .opcode (opcode),
    .x      (x_in),
    .y      (y_in),
    .ci     (flg_q.ac),
    .res    (raw),
    .flags  (nxt)
  );

  sat_alu_clamp #(.WIDTH(WIDTH)) u_clamp (
    .raw      (raw),
    .sat_en   (sat_en),
    .av       (nxt.av),
    .ac       (nxt.ac),
    .load_val (load_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      r_out <= '0;
      flg_q <= '0;
    end else begin
      r_out <= load_val;
      flg_q <= nxt;
    end
  end

  assign az     = flg_q.az;
  assign an     = flg_q.an;
  assign ac     = flg_q.ac;
  assign av     = flg_q.av;
  assign x_sign = flg_q.xs;
  assign aq     = flg_q.aq;
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             sat_en,
  input logic [4:0]       opcode,
  input logic [WIDTH-1:0] x_in,
  input logic [WIDTH-1:0] r_out,
  input logic             az,
  input logic             an,
  input logic             ac,
  input logic             av,
  input logic             x_sign,
  input logic             aq
);
  localparam logic [WIDTH-1:0] FULL_POS = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] FULL_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic no_arith, is_clear;
  assign is_clear = (opcode == 5'd12) || (opcode > 5'd18);
  assign no_arith = is_clear || (opcode == 5'd10) || (opcode == 5'd11) ||
                    ((opcode >= 5'd14) && (opcode <= 5'd18));

  p_aq_low_r8: assert property (@(posedge clk) disable iff (rst) aq == 1'b0);

  p_xsign_r8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> x_sign == $past(x_in[WIDTH-1]));

  p_logic_noflags_r5: assert property (@(posedge clk) disable iff (rst)
    (!rst && no_arith) |=> (!ac && !av));

  p_clear_r12: assert property (@(posedge clk) disable iff (rst)
    (!rst && is_clear) |=> (r_out == '0 && az && !an));

  p_zero_neg_r6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (av || (az == (r_out == '0) && an == r_out[WIDTH-1])));

  p_sat_pos_r10: assert property (@(posedge clk) disable iff (rst)
    (!rst && sat_en) |=> (!(av && !ac) || r_out == FULL_POS));

  p_sat_neg_r10: assert property (@(posedge clk) disable iff (rst)
    (!rst && sat_en) |=> (!(av && ac) || r_out == FULL_NEG));

  p_wrap_sign_r11: assert property (@(posedge clk) disable iff (rst)
    (!rst && !sat_en) |=> (!av || r_out[WIDTH-1] == !ac));
endmodule

bind sat_alu sat_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .sat_en (sat_en),
  .opcode (opcode),
  .x_in   (x_in),
  .r_out  (r_out),
  .az     (az),
  .an     (an),
  .ac     (ac),
  .av     (av),
  .x_sign (x_sign),
  .aq     (aq)
);

// File: tb/sat_alu_test.sv
module sat_alu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sat_en = 1'b0;
  logic [4:0]  opcode = 5'd0;
  logic [15:0] x_in = 16'h0;
  logic [15:0] y_in = 16'h0;
  logic [15:0] r_out;
  logic        az, an, ac, av, x_sign, aq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state: stored carry
  bit          m_ac = 1'b0;
  logic [15:0] e_r;
  bit          e_az, e_an, e_ac, e_av, e_xs;

  always #10 clk = ~clk;

  sat_alu uut (
    .clk(clk), .rst(rst), .sat_en(sat_en), .opcode(opcode),
    .x_in(x_in), .y_in(y_in), .r_out(r_out), .az(az), .an(an),
    .ac(ac), .av(av), .x_sign(x_sign), .aq(aq)
  );

  // Reference: signed value range decides overflow (R4), unsigned sum decides carry.
  task automatic model(input logic [4:0] op, input logic [15:0] x, input logic [15:0] y,
                       input bit ci, input bit sat);
    int sx, sy, ux, uy, tv, cu;
    bit arith;
    logic [15:0] res;
    sx = int'($signed(x));
    sy = int'($signed(y));
    ux = int'(x);
    uy = int'(y);
    tv = 0; cu = 0; arith = 1'b1; res = 16'h0;
    case (op)
      5'd0:  begin tv = sx + sy;          cu = ux + uy; end
      5'd1:  begin tv = sx + sy + ci;     cu = ux + uy + ci; end  // R3
      5'd2:  begin tv = sx - sy;          cu = ux + (65535 - uy) + 1; end
      5'd3:  begin tv = sx - sy + ci - 1; cu = ux + (65535 - uy) + ci; end
      5'd4:  begin tv = sy - sx;          cu = uy + (65535 - ux) + 1; end
      5'd5:  begin tv = sy - sx + ci - 1; cu = uy + (65535 - ux) + ci; end
      5'd6:  begin tv = -sx;              cu = (65535 - ux) + 1; end
      5'd7:  begin tv = -sy;              cu = (65535 - uy) + 1; end
      5'd8:  begin tv = sy + 1;           cu = uy + 1; end
      5'd9:  begin tv = sy - 1;           cu = uy + 65535; end
      5'd13: begin
        if (sx < 0) begin tv = -sx; cu = (65535 - ux) + 1; end
        else        begin tv = sx;  cu = ux; end
      end
      5'd10: begin arith = 1'b0; res = x; end
      5'd11: begin arith = 1'b0; res = y; end
      5'd14: begin arith = 1'b0; res = x & y; end
      5'd15: begin arith = 1'b0; res = x | y; end
      5'd16: begin arith = 1'b0; res = x ^ y; end
      5'd17: begin arith = 1'b0; res = ~x; end
      5'd18: begin arith = 1'b0; res = ~y; end
      default: begin arith = 1'b0; res = 16'h0; end  // 12 and R12 codes
    endcase
    if (arith) begin
      res  = tv[15:0];
      e_ac = (cu > 65535);
      e_av = (tv > 32767) || (tv < -32768);
    end else begin
      e_ac = 1'b0;  // R5
      e_av = 1'b0;
    end
    e_az = (res == 16'h0);  // R6: from the unsaturated value
    e_an = res[15];
    e_xs = x[15];           // R8
    if (sat && e_av) e_r = e_ac ? 16'h8000 : 16'h7FFF;  // R10
    else             e_r = res;                          // R9, R11
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge: drive, then compare one falling edge later,
  // after exactly one register stage (R13).
  task automatic run_op(input logic [4:0] op, input logic [15:0] x, input logic [15:0] y,
                        input bit sat);
    string rq;
    opcode = op; x_in = x; y_in = y; sat_en = sat;
    model(op, x, y, m_ac, sat);
    if (op == 5'd13 && x == 16'h8000) rq = "R7";
    else if (sat && e_av)             rq = "R10";
    else if (e_av)                    rq = "R11";
    else if (op > 5'd18)              rq = "R12";
    else if (sat)                     rq = "R9";
    else if (op == 5'd1 || op == 5'd3 || op == 5'd5) rq = "R3";
    else                              rq = "R2";
    @(negedge clk);
    check(r_out == e_r, rq, $sformatf("result op=%0d", op), r_out, e_r);
    check(ac == e_ac && av == e_av, "R4", $sformatf("ac/av op=%0d", op),
          {14'h0, ac, av}, {14'h0, e_ac, e_av});
    check(az == e_az && an == e_an, "R6", $sformatf("az/an op=%0d", op),
          {14'h0, az, an}, {14'h0, e_az, e_an});
    check(x_sign == e_xs && aq == 1'b0, "R8", $sformatf("x_sign/aq op=%0d", op),
          {14'h0, x_sign, aq}, {14'h0, e_xs, 1'b0});
    m_ac = e_ac;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    opcode = 5'd0; x_in = 16'h7FFF; y_in = 16'h0001; sat_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R1: inputs would overflow, but reset wins
    check(r_out == 16'h0 && {az, an, ac, av, x_sign, aq} == 6'b0, "R1", "reset state",
          r_out, 16'h0);
    rst = 1'b0;
    m_ac = 1'b0;
  endtask

  logic [15:0] corner [5];

  initial begin
    corner[0] = 16'h0000; corner[1] = 16'h0001; corner[2] = 16'h7FFF;
    corner[3] = 16'h8000; corner[4] = 16'hFFFF;
    @(negedge clk);
    do_reset();
    // directed sweep: every code, every corner pair, both modes
    for (int s = 0; s < 2; s++)
      for (int op = 0; op < 32; op++)
        for (int i = 0; i < 5; i++)
          for (int j = 0; j < 5; j++)
            run_op(5'(op), corner[i], corner[j], s[0]);
    // multiprecision chain: 0x0001_FFFF + 0x0000_0001 (R3)
    run_op(5'd0, 16'hFFFF, 16'h0001, 1'b0);
    run_op(5'd1, 16'h0001, 16'h0000, 1'b0);
    check(r_out == 16'h0002, "R3", "carry chained into high word", r_out, 16'h0002);
    // borrow chain: 0x0001_0000 - 0x0000_0001
    run_op(5'd2, 16'h0000, 16'h0001, 1'b0);
    run_op(5'd3, 16'h0001, 16'h0000, 1'b0);
    check(r_out == 16'h0000, "R3", "borrow chained into high word", r_out, 16'h0000);
    // random traffic
    for (int k = 0; k < 3000; k++)
      run_op(5'($urandom_range(0, 31)), 16'($urandom), 16'($urandom), 1'($urandom));
    do_reset();
    for (int k = 0; k < 500; k++)
      run_op(5'($urandom_range(0, 18)), 16'($urandom), 16'($urandom), 1'($urandom));
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule